// File: doc/BRIEF.md
# Alternating-Channel Converter Result Reader

This block is the host side of a three-wire serial link to a two-channel delta-sigma converter that converts its channels in turn. While enabled, it lowers chip select and polls the converter's data line. When that line goes low, a result is ready. The block then drives a serial clock derived from the system clock and captures a 19-bit word on the rising edges. The word holds a ready bit, a channel tag, a sign bit and a 16-bit magnitude field.

Each accepted word is decoded into a signed 17-bit value and sent to the output register of the channel its tag names. That channel gets a one-cycle strobe and range flags. The other channel's register keeps its value. The block also reports a repeated tag as a sequence error, because the converter is expected to alternate between its two channels. After every word, chip select stays high for a programmable idle time before polling starts again.

Top module: `pp_frame_reader`

## Requirements
- R1: While reset is high and in the cycle after it, chip select (`cs_n_o`) is high, the serial clock is low, and both strobes, both values and the sequence-error output are 0.
- R2: After chip select falls, no rising serial-clock edge is produced until the data line has been seen low (the ready bit, frame bit 18, equals 0).
- R3: Every low phase of chip select contains exactly 19 rising serial-clock edges, and the serial clock is low whenever chip select is high.
- R4: Between consecutive serial-clock edges inside a frame there are exactly `DIV_HALF` system-clock cycles.
- R5: Between two frames, chip select stays high for at least `IDLE_CYC` system-clock cycles.
- R6: Bits are captured most significant first. Bit 16 is the sign, and bits 15..0 are the magnitude with bit 15 as its MSB. The output value is {~sign, magnitude} read as 17-bit two's complement, so sign 1 with magnitude 0 gives 0, and sign 0 with magnitude 0xFFFF gives -1.
- R7: Bit 17 selects the channel (0 gives channel 0, 1 gives channel 1). The selected channel's strobe is high for exactly one cycle with the new value. The other channel's value is unchanged.
- R8: The over flag is 1 exactly when sign = 1 and magnitude = 0x8000. The under flag is 1 exactly when sign = 0 and magnitude = 0x7FFF. Both flags are registered with the value.
- R9: `seq_err_o` pulses together with a strobe when the word's tag equals the tag of the previous accepted word. It is 0 for the first word after reset and at all other times.
- R10: When `enable_i` is low, a frame already under way is completed and delivered. After that, chip select stays high.
- R11: `last_tag_o` holds the channel tag of the most recently delivered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Run enable for continuous polling |
| sdo_i | input | 1 | Serial data from the converter |
| sck_o | output | 1 | Generated serial clock, idle low |
| cs_n_o | output | 1 | Active-low chip select |
| ch0_value_o | output | 17 | Signed result for channel 0 |
| ch0_valid_o | output | 1 | One-cycle strobe for a new channel 0 result |
| ch0_over_o | output | 1 | Channel 0 positive clamp code seen |
| ch0_under_o | output | 1 | Channel 0 negative clamp code seen |
| ch1_value_o | output | 17 | Signed result for channel 1 |
| ch1_valid_o | output | 1 | One-cycle strobe for a new channel 1 result |
| ch1_over_o | output | 1 | Channel 1 positive clamp code seen |
| ch1_under_o | output | 1 | Channel 1 negative clamp code seen |
| last_tag_o | output | 1 | Tag of the latest delivered word |
| seq_err_o | output | 1 | Pulse: tag repeated from the previous word |

## Verification
The bench builds the reader with `DIV_HALF` = 4 and `IDLE_CYC` = 6, and leaves the synchronizer at two stages. These settings make a frame about 160 cycles long. Within the run length, the bench can therefore deliver 25 words that cover the zero and minus-one codes, both clamp codes, random codes and one deliberately repeated tag. At that divide, the synchronizer latency still fits inside one serial-clock half period, so data that changes on the falling edge has settled by the next rising edge. The bench also tries ready delays of 0 to 20 cycles against the polling tick.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int FRAME_BITS = 19;
    localparam int MAG_BITS   = 16;
    localparam int RES_BITS   = MAG_BITS + 1;
    localparam int RDY_POS    = FRAME_BITS - 1;
    localparam int TAG_POS    = FRAME_BITS - 2;
    localparam int SIGN_POS   = MAG_BITS;
    localparam int NUM_CH     = 2;

    localparam logic [MAG_BITS-1:0] POS_CLAMP_MAG = {1'b1, {(MAG_BITS-1){1'b0}}};
    localparam logic [MAG_BITS-1:0] NEG_CLAMP_MAG = {1'b0, {(MAG_BITS-1){1'b1}}};

    typedef logic [FRAME_BITS-1:0] frame_t;

    typedef struct packed {
        logic                       ok;
        logic                       tag;
        logic signed [RES_BITS-1:0] value;
        logic                       over;
        logic                       under;
    } result_t;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_POLL  = 2'd1,
        RD_SHIFT = 2'd2
    } rd_state_e;

    function automatic logic signed [RES_BITS-1:0] code_to_signed(
        input logic                sign,
        input logic [MAG_BITS-1:0] mag
    );
        return {~sign, mag};
    endfunction

endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
    parameter int   STAGES   = 2,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pp_sck_gen.sv
module pp_sck_gen #(
    parameter int DIV_HALF = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = $clog2(DIV_HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run_i)     cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign tick_o = run_i && (cnt == LAST);
endmodule

// File: rtl/pp_frame_ctrl.sv
module pp_frame_ctrl
    import pp_pkg::*;
#(
    parameter int IDLE_CYC = 100
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   enable_i,
    input  logic   sdo_s_i,
    input  logic   tick_i,
    output logic   run_o,
    output logic   sck_o,
    output logic   cs_n_o,
    output logic   frame_stb_o,
    output frame_t frame_o
);
    localparam int BW = $clog2(FRAME_BITS + 1);
    localparam int IW = $clog2(IDLE_CYC + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS);

    rd_state_e     state;
    logic [BW-1:0] bit_cnt;
    logic [IW-1:0] idle_cnt;
    frame_t        shreg;
    logic          sck_q;
    logic          cs_n_q;
    logic          stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RD_IDLE;
            bit_cnt  <= '0;
            idle_cnt <= '0;
            shreg    <= '0;
            sck_q    <= 1'b0;
            cs_n_q   <= 1'b1;
            stb_q    <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            unique case (state)
                RD_IDLE: begin
                    if (idle_cnt != '0) begin
                        idle_cnt <= idle_cnt - 1'b1;
                    end else if (enable_i) begin
                        cs_n_q  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= RD_POLL;
                    end
                end
                RD_POLL: begin
                    if (tick_i && !sdo_s_i) begin
                        state <= RD_SHIFT;
                    end
                end
                RD_SHIFT: begin
                    if (tick_i) begin
                        if (!sck_q) begin
                            sck_q   <= 1'b1;
                            shreg   <= {shreg[FRAME_BITS-2:0], sdo_s_i};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else begin
                            sck_q <= 1'b0;
                            if (bit_cnt == LAST_BIT) begin
                                cs_n_q   <= 1'b1;
                                stb_q    <= 1'b1;
                                idle_cnt <= IW'(IDLE_CYC);
                                state    <= RD_IDLE;
                            end
                        end
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    assign run_o       = (state == RD_POLL) || (state == RD_SHIFT);
    assign sck_o       = sck_q;
    assign cs_n_o      = cs_n_q;
    assign frame_stb_o = stb_q;
    assign frame_o     = shreg;
endmodule

// File: rtl/pp_decode.sv
module pp_decode
    import pp_pkg::*;
(
    input  frame_t  frame_i,
    output result_t res_o
);
    logic                sign;
    logic [MAG_BITS-1:0] mag;

    assign sign = frame_i[SIGN_POS];
    assign mag  = frame_i[MAG_BITS-1:0];

    always_comb begin
        res_o.ok    = ~frame_i[RDY_POS];
        res_o.tag   = frame_i[TAG_POS];
        res_o.value = code_to_signed(sign, mag);
        res_o.over  = sign && (mag == POS_CLAMP_MAG);
        res_o.under = !sign && (mag == NEG_CLAMP_MAG);
    end
endmodule

// File: rtl/pp_result_bank.sv
module pp_result_bank
    import pp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       stb_i,
    input  result_t                    res_i,
    output logic signed [RES_BITS-1:0] value_o [NUM_CH],
    output logic [NUM_CH-1:0]          valid_o,
    output logic [NUM_CH-1:0]          over_o,
    output logic [NUM_CH-1:0]          under_o,
    output logic                       last_tag_o,
    output logic                       seq_err_o
);
    logic accept;
    logic have_prev;

    assign accept = stb_i && res_i.ok;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic hit;
            assign hit = accept && (res_i.tag == c[0]);
            always_ff @(posedge clk) begin
                if (rst) begin
                    value_o[c] <= '0;
                    valid_o[c] <= 1'b0;
                    over_o[c]  <= 1'b0;
                    under_o[c] <= 1'b0;
                end else begin
                    valid_o[c] <= hit;
                    if (hit) begin
                        value_o[c] <= res_i.value;
                        over_o[c]  <= res_i.over;
                        under_o[c] <= res_i.under;
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev  <= 1'b0;
            last_tag_o <= 1'b0;
            seq_err_o  <= 1'b0;
        end else begin
            seq_err_o <= accept && have_prev && (last_tag_o == res_i.tag);
            if (accept) begin
                have_prev  <= 1'b1;
                last_tag_o <= res_i.tag;
            end
        end
    end
endmodule

// File: rtl/pp_frame_reader.sv
module pp_frame_reader
    import pp_pkg::*;
#(
    parameter int DIV_HALF    = 50,
    parameter int IDLE_CYC    = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable_i,
    input  logic                       sdo_i,
    output logic                       sck_o,
    output logic                       cs_n_o,
    output logic signed [RES_BITS-1:0] ch0_value_o,
    output logic                       ch0_valid_o,
    output logic                       ch0_over_o,
    output logic                       ch0_under_o,
    output logic signed [RES_BITS-1:0] ch1_value_o,
    output logic                       ch1_valid_o,
    output logic                       ch1_over_o,
    output logic                       ch1_under_o,
    output logic                       last_tag_o,
    output logic                       seq_err_o
);
    logic                       sdo_s;
    logic                       run;
    logic                       tick;
    logic                       frame_stb;
    frame_t                     frame;
    result_t                    res;
    logic signed [RES_BITS-1:0] values [NUM_CH];
    logic [NUM_CH-1:0]          valids;
    logic [NUM_CH-1:0]          overs;
    logic [NUM_CH-1:0]          unders;

    pp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sdo_i),
        .q_o (sdo_s)
    );

    pp_sck_gen #(.DIV_HALF(DIV_HALF)) u_sck (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .tick_o (tick)
    );

    pp_frame_ctrl #(.IDLE_CYC(IDLE_CYC)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .enable_i    (enable_i),
        .sdo_s_i     (sdo_s),
        .tick_i      (tick),
        .run_o       (run),
        .sck_o       (sck_o),
        .cs_n_o      (cs_n_o),
        .frame_stb_o (frame_stb),
        .frame_o     (frame)
    );

    pp_decode u_dec (
        .frame_i (frame),
        .res_o   (res)
    );

    pp_result_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .stb_i      (frame_stb),
        .res_i      (res),
        .value_o    (values),
        .valid_o    (valids),
        .over_o     (overs),
        .under_o    (unders),
        .last_tag_o (last_tag_o),
        .seq_err_o  (seq_err_o)
    );

    assign ch0_value_o = values[0];
    assign ch1_value_o = values[1];
    assign ch0_valid_o = valids[0];
    assign ch1_valid_o = valids[1];
    assign ch0_over_o  = overs[0];
    assign ch1_over_o  = overs[1];
    assign ch0_under_o = unders[0];
    assign ch1_under_o = unders[1];
endmodule

// File: rtl/pp_frame_reader_chk.sv
module pp_frame_reader_chk (
    input logic clk,
    input logic rst,
    input logic sck_o,
    input logic cs_n_o,
    input logic ch0_valid_o,
    input logic ch1_valid_o,
    input logic ch0_over_o,
    input logic ch0_under_o,
    input logic ch1_over_o,
    input logic ch1_under_o,
    input logic seq_err_o
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (cs_n_o && !sck_o && !ch0_valid_o && !ch1_valid_o));

    // R3
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (rst) cs_n_o |-> !sck_o);

    // R4
    sck_high_hold_chk: assert property (@(posedge clk) disable iff (rst) $rose(sck_o) |=> sck_o);

    // R7
    valid_excl_chk: assert property (@(posedge clk) disable iff (rst) !(ch0_valid_o && ch1_valid_o));

    // R7
    ch0_pulse_chk: assert property (@(posedge clk) disable iff (rst) ch0_valid_o |=> !ch0_valid_o);

    // R7
    ch1_pulse_chk: assert property (@(posedge clk) disable iff (rst) ch1_valid_o |=> !ch1_valid_o);

    // R8
    range_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ch0_over_o && ch0_under_o) && !(ch1_over_o && ch1_under_o));

    // R9
    seq_with_valid_chk: assert property (@(posedge clk) disable iff (rst) seq_err_o |-> (ch0_valid_o || ch1_valid_o));
endmodule

bind pp_frame_reader pp_frame_reader_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sck_o       (sck_o),
    .cs_n_o      (cs_n_o),
    .ch0_valid_o (ch0_valid_o),
    .ch1_valid_o (ch1_valid_o),
    .ch0_over_o  (ch0_over_o),
    .ch0_under_o (ch0_under_o),
    .ch1_over_o  (ch1_over_o),
    .ch1_under_o (ch1_under_o),
    .seq_err_o   (seq_err_o)
);

// File: tb/tb_pp_frame_reader.sv
module tb_pp_frame_reader;
    localparam int DIVH  = 4;
    localparam int IDLE  = 6;
    localparam int NFR   = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic sdo = 1'b1;
    logic sck, cs_n, v0, v1, o0, o1, u0, u1, ltag, serr;
    logic signed [16:0] val0, val1;

    always #2.5 clk = ~clk;

    pp_frame_reader #(.DIV_HALF(DIVH), .IDLE_CYC(IDLE)) dut (
        .clk(clk), .rst(rst), .enable_i(enable), .sdo_i(sdo),
        .sck_o(sck), .cs_n_o(cs_n),
        .ch0_value_o(val0), .ch0_valid_o(v0), .ch0_over_o(o0), .ch0_under_o(u0),
        .ch1_value_o(val1), .ch1_valid_o(v1), .ch1_over_o(o1), .ch1_under_o(u1),
        .last_tag_o(ltag), .seq_err_o(serr)
    );

    int checks = 0;
    int fails  = 0;
    int done_frames = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // converter model state
    int  q_tag[$], q_val[$], q_ov[$], q_un[$], q_se[$];
    int  frame_no = 0;
    bit  m_active = 0, m_ready = 0, m_prev_sck = 0;
    int  m_wait = 0, m_idx = 0, m_rises = 0;
    logic [18:0] m_frame;
    bit  pick_tag = 1'b1;
    bit  sent_have_prev = 0;
    bit  sent_prev_tag = 0;

    function automatic logic [18:0] pick_frame(input int n, input bit tag);
        logic        s;
        logic [15:0] d;
        case (n)
            0: begin s = 1'b1; d = 16'h0000; end
            1: begin s = 1'b0; d = 16'hFFFF; end
            2: begin s = 1'b1; d = 16'h8000; end
            3: begin s = 1'b0; d = 16'h7FFF; end
            4: begin s = 1'b1; d = 16'h0001; end
            5: begin s = 1'b0; d = 16'h0000; end
            6: begin s = 1'b0; d = 16'h7FFF; end
            7: begin s = 1'b1; d = 16'h8000; end
            default: begin s = 1'($urandom); d = 16'($urandom); end
        endcase
        return {1'b0, tag, s, d};
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            sdo = 1'b1;
            m_active = 0; m_ready = 0;
        end else if (cs_n) begin
            sdo = 1'b1;
            m_active = 0; m_ready = 0;
        end else begin
            if (!m_active) begin
                m_active = 1; m_ready = 0; m_rises = 0;
                m_wait = $urandom_range(0, 20);
                if (frame_no != 11) pick_tag = ~pick_tag;
                m_frame = pick_frame(frame_no, pick_tag);
                frame_no++;
            end
            if (!m_ready) begin
                if (sck) chk(1'b0, "R2 edge before ready", 1, 0);
                if (m_wait == 0) begin
                    m_ready = 1; m_idx = 18; sdo = m_frame[18];
                end else begin
                    m_wait--; sdo = 1'b1;
                end
            end else if (sck && !m_prev_sck) begin
                m_rises++;
                if (m_rises == 1) chk(1'b1, "R2", 0, 0);
                if (m_rises == 19) begin
                    int v;
                    v = m_frame[16] ? int'(m_frame[15:0]) : int'(m_frame[15:0]) - 65536;
                    q_tag.push_back(int'(m_frame[17]));
                    q_val.push_back(v);
                    q_ov.push_back(int'(m_frame[16] && m_frame[15:0] == 16'h8000));
                    q_un.push_back(int'(!m_frame[16] && m_frame[15:0] == 16'h7FFF));
                    q_se.push_back(int'(sent_have_prev && sent_prev_tag == m_frame[17]));
                    sent_have_prev = 1; sent_prev_tag = m_frame[17];
                end
            end else if (!sck && m_prev_sck) begin
                if (m_idx > 0) begin m_idx--; sdo = m_frame[m_idx]; end
            end
        end
        m_prev_sck = sck;
    end

    // timing monitor
    bit prev_sck_t = 0, prev_cs = 1, seen_edge = 0, first_low = 1;
    int since_edge = 0, rises_win = 0, high_len = 0;

    always @(negedge clk) begin
        if (!rst) begin
            since_edge++;
            if (sck != prev_sck_t) begin
                if (seen_edge) chk(since_edge == DIVH, "R4 half period", since_edge, DIVH);
                seen_edge = 1; since_edge = 0;
                if (sck) rises_win++;
            end
            if (cs_n && sck) chk(1'b0, "R3 sck high while deselected", 1, 0);
            if (cs_n && !prev_cs) begin
                chk(rises_win == 19, "R3 rising edges", rises_win, 19);
                high_len = 0;
            end
            if (cs_n) high_len++;
            if (!cs_n && prev_cs) begin
                if (!first_low) chk(high_len >= IDLE, "R5 idle length", high_len, IDLE);
                first_low = 0; rises_win = 0; seen_edge = 0;
            end
            prev_sck_t = sck; prev_cs = cs_n;
        end
    end

    // result checker
    longint last0 = 0, last1 = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (v0 || v1) begin
                if (q_tag.size() == 0) begin
                    chk(1'b0, "R7 unexpected strobe", 1, 0);
                end else begin
                    int t, ev, eo, eu, es;
                    t = q_tag.pop_front(); ev = q_val.pop_front();
                    eo = q_ov.pop_front(); eu = q_un.pop_front(); es = q_se.pop_front();
                    chk(v1 == t[0], "R7 steering", v1, t);
                    chk(ltag == t[0], "R11 tag", ltag, t);
                    chk(serr == es[0], "R9 seq err", serr, es);
                    if (t == 0) begin
                        chk(val0 == ev, "R6 ch0 value", val0, ev);
                        chk(o0 == eo[0] && u0 == eu[0], "R8 ch0 flags", {o0, u0}, eo * 2 + eu);
                        chk(val1 == last1, "R7 ch1 held", val1, last1);
                        last0 = ev;
                    end else begin
                        chk(val1 == ev, "R6 ch1 value", val1, ev);
                        chk(o1 == eo[0] && u1 == eu[0], "R8 ch1 flags", {o1, u1}, eo * 2 + eu);
                        chk(val0 == last0, "R7 ch0 held", val0, last0);
                        last1 = ev;
                    end
                    done_frames++;
                end
            end else if (serr) begin
                chk(1'b0, "R9 seq err without strobe", 1, 0);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", done_frames, NFR);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1
        chk(cs_n == 1'b1 && sck == 1'b0, "R1 bus idle", {cs_n, sck}, 2);
        chk(!v0 && !v1 && !serr, "R1 strobes", {v0, v1, serr}, 0);
        chk(val0 == 0 && val1 == 0, "R1 values", val0, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1 && sck == 1'b0, "R1 after release", {cs_n, sck}, 2);
        enable = 1'b1;
        while (done_frames < NFR - 1) @(negedge clk);
        while (cs_n) @(negedge clk);
        enable = 1'b0;   // R10: frame in flight must complete
        while (done_frames < NFR) @(negedge clk);
        begin
            bit stayed = 1;
            repeat (400) begin
                @(negedge clk);
                if (!cs_n) stayed = 0;
            end
            chk(stayed, "R10 stays deselected", !stayed, 0);
        end
        chk(q_tag.size() == 0, "R10 all words delivered", q_tag.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule